// File: doc/BRIEF.md
# Address Register and Incrementer Unit

This block keeps the address-side registers of a small 8-bit processor: a 16-bit program counter split into low and high bytes, a 16-bit data pointer split the same way, an 8-bit stack pointer and an 8-bit temporary byte. Microcode fields pick which register takes a byte from the write bus and which register steps through the shared 16-bit incrementer. A separate field places one register byte on the read bus.

An address-mode multiplexer forms the 16-bit internal address. Some modes take a full register pair. Others force the high byte to a fixed page: $00, $01 or $FF. When the data pointer is stepped, only its low byte moves, so the pointer wraps inside its current page. The high data-pointer byte can also be loaded straight from the external data bus. An inhibit input freezes the program counter while interrupt entry is in progress. An active-low bus enable decides whether the internal address drives the external address pins or releases them.

The block has no state machine. Every register updates on the rising clock edge, and reset is synchronous and active high.

Top module: `addr_reg_unit`

## Requirements
- R1: After reset, every register reads as zero on the read bus, and the internal address is $0000.
- R2: The `mode` input selects the internal address as follows. 0 gives PCH:PCL. 1 gives DPH:DPL. 2 gives $01:SP. 3 gives $00:DPL. 4 gives $FF:DPL. 5 gives DPH:TMP. Codes 6 and 7 behave like code 0.
- R3: While `bus_en_n` is 0, `ext_addr` equals `int_addr`. While it is 1, `ext_addr` is released to high impedance.
- R4: `wr_sel` loads `wbus` at the clock edge into the register it names: 1 PCL, 2 PCH, 3 DPL, 4 DPH, 5 SP, 6 TMP. Codes 0 and 7 load nothing.
- R5: With `inc_sel` = 1, the 16-bit program counter increments by one, and the carry passes from PCL into PCH. It wraps from $FFFF to $0000.
- R6: With `inc_sel` = 2, DPL increments modulo 256 and DPH keeps its value.
- R7: With `inc_sel` = 3, SP increments modulo 256. With `inc_sel` = 4, TMP increments modulo 256. Codes 0, 5, 6 and 7 step nothing.
- R8: While `dph_load` is 1, DPH takes `dbus`. This has priority over a write-bus load of DPH in the same cycle.
- R9: While `inhibit_pc` is 1, neither PC byte changes, whatever `wr_sel` or `inc_sel` request.
- R10: If the write bus and the incrementer target the same register byte in one cycle, the write-bus value wins for that byte. The other byte of the pair still takes the incremented value.
- R11: `rd_sel` puts one byte on `rd_bus`: 0 PCL, 1 PCH, 2 DPL, 3 DPH, 4 SP, 5 TMP. Codes 6 and 7 give $00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wbus | input | 8 | Write bus data |
| wr_sel | input | 3 | Register that takes `wbus` |
| inc_sel | input | 3 | Register that steps through the incrementer |
| dbus | input | 8 | External data bus, used for the direct DPH load |
| dph_load | input | 1 | Loads DPH from `dbus` |
| inhibit_pc | input | 1 | Freezes the program counter |
| mode | input | 3 | Address mode select |
| rd_sel | input | 3 | Read bus source select |
| bus_en_n | input | 1 | Active-low enable for the external address |
| rd_bus | output | 8 | Read bus data |
| int_addr | output | 16 | Internal address |
| ext_addr | output | 16 | External address, high impedance when not enabled |

## Verification
Long runs of increments are checked step by step against arithmetic expectations.
- The stack pointer is stepped past $FF, which separates 8-bit wrap from a carry that leaks upward.
- The data pointer is started just below a page end. This shows whether DPH moves when it must not.
- The program counter is swept across several $xxFF boundaries. This exposes a broken nibble or byte lookahead carry.

All six address modes, plus both unused mode codes, are tried with distinct register contents, so that a swapped byte or a wrong fixed page shows up. Conflicting same-cycle requests are also applied: inhibit with a load, DPH direct load against a bus write, and a bus write against an increment. These confirm the priority order.

// File: rtl/addr_unit_pkg.sv
package addr_unit_pkg;

    typedef enum logic [2:0] {
        AM_PC  = 3'd0,
        AM_DP  = 3'd1,
        AM_SP  = 3'd2,
        AM_ZPG = 3'd3,
        AM_FPG = 3'd4,
        AM_DPT = 3'd5
    } addr_mode_e;

    typedef enum logic [2:0] {
        WS_NONE = 3'd0,
        WS_PCL  = 3'd1,
        WS_PCH  = 3'd2,
        WS_DPL  = 3'd3,
        WS_DPH  = 3'd4,
        WS_SP   = 3'd5,
        WS_TMP  = 3'd6
    } wr_sel_e;

    typedef enum logic [2:0] {
        IS_NONE = 3'd0,
        IS_PC   = 3'd1,
        IS_DP   = 3'd2,
        IS_SP   = 3'd3,
        IS_TMP  = 3'd4
    } inc_sel_e;

    typedef enum logic [2:0] {
        RS_PCL = 3'd0,
        RS_PCH = 3'd1,
        RS_DPL = 3'd2,
        RS_DPH = 3'd3,
        RS_SP  = 3'd4,
        RS_TMP = 3'd5
    } rd_sel_e;

    typedef struct packed {
        logic [7:0] pcl;
        logic [7:0] pch;
        logic [7:0] dpl;
        logic [7:0] dph;
        logic [7:0] sp;
        logic [7:0] tmp;
    } areg_t;

endpackage

// File: rtl/au_incrementer.sv
module au_incrementer #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] operand,
    output logic [WIDTH-1:0] result
);
    localparam int NGRP = WIDTH / GROUP;

    logic [NGRP:0]   grp_cin;
    logic [NGRP-1:0] grp_all_ones;

    assign grp_cin[0] = 1'b1;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_all_ones[g] = &operand[g*GROUP +: GROUP];
        // lookahead: a group receives a carry only when every lower group is all ones
        assign grp_cin[g+1]    = grp_cin[g] & grp_all_ones[g];
        assign result[g*GROUP +: GROUP] =
            operand[g*GROUP +: GROUP] + {{(GROUP-1){1'b0}}, grp_cin[g]};
    end

    always_comb begin
        assert_inc_sum_R5: assert (result == operand + 1'b1)
            else $error("incrementer lookahead sum wrong");
    end

endmodule

// File: rtl/au_regfile.sv
module au_regfile
    import addr_unit_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wbus,
    input  wr_sel_e       wr_sel,
    input  inc_sel_e      inc_sel,
    input  logic [2*DW-1:0] sbus,
    input  logic [DW-1:0] dbus,
    input  logic          dph_load,
    input  logic          inhibit_pc,
    output areg_t         regs
);
    localparam logic [DW-1:0] ZERO = '0;

    logic [DW-1:0] s_lo, s_hi;
    assign s_lo = sbus[DW-1:0];
    assign s_hi = sbus[2*DW-1:DW];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.pcl <= ZERO;
            regs.pch <= ZERO;
            regs.dpl <= ZERO;
            regs.dph <= ZERO;
            regs.sp  <= ZERO;
            regs.tmp <= ZERO;
        end else begin
            if (!inhibit_pc) begin
                if (wr_sel == WS_PCL)      regs.pcl <= wbus;
                else if (inc_sel == IS_PC) regs.pcl <= s_lo;
                if (wr_sel == WS_PCH)      regs.pch <= wbus;
                else if (inc_sel == IS_PC) regs.pch <= s_hi;
            end
            if (wr_sel == WS_DPL)      regs.dpl <= wbus;
            else if (inc_sel == IS_DP) regs.dpl <= s_lo;
            if (dph_load)              regs.dph <= dbus;
            else if (wr_sel == WS_DPH) regs.dph <= wbus;
            if (wr_sel == WS_SP)       regs.sp  <= wbus;
            else if (inc_sel == IS_SP) regs.sp  <= s_lo;
            if (wr_sel == WS_TMP)       regs.tmp <= wbus;
            else if (inc_sel == IS_TMP) regs.tmp <= s_lo;
        end
    end

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_sel == IS_PC && !inhibit_pc && wr_sel != WS_PCL && wr_sel != WS_PCH)
        |=> {regs.pch, regs.pcl} == $past({regs.pch, regs.pcl}) + 1'b1)
        else $error("PC increment wrong");

    assert_dp_page_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (inc_sel == IS_DP && !dph_load && wr_sel != WS_DPL && wr_sel != WS_DPH)
        |=> (regs.dpl == DW'($past(regs.dpl) + 1'b1)) && (regs.dph == $past(regs.dph)))
        else $error("DP increment left its page");

    assert_sp_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (inc_sel == IS_SP && wr_sel != WS_SP)
        |=> regs.sp == DW'($past(regs.sp) + 1'b1))
        else $error("SP increment wrong");

    assert_pc_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        inhibit_pc |=> $stable({regs.pch, regs.pcl}))
        else $error("PC changed while inhibited");

    assert_dph_direct_R8: assert property (@(posedge clk) disable iff (rst)
        dph_load |=> regs.dph == $past(dbus))
        else $error("DPH direct load lost");

endmodule

// File: rtl/au_addr_mux.sv
module au_addr_mux
    import addr_unit_pkg::*;
#(
    parameter int         DW        = 8,
    parameter logic [7:0] ZERO_PAGE = 8'h00,
    parameter logic [7:0] STK_PAGE  = 8'h01,
    parameter logic [7:0] TOP_PAGE  = 8'hFF
) (
    input  areg_t           regs,
    input  addr_mode_e      mode,
    input  rd_sel_e         rd_sel,
    output logic [2*DW-1:0] addr,
    output logic [DW-1:0]   rd_bus
);
    always_comb begin
        unique case (mode)
            AM_DP:   addr = {regs.dph, regs.dpl};
            AM_SP:   addr = {STK_PAGE, regs.sp};
            AM_ZPG:  addr = {ZERO_PAGE, regs.dpl};
            AM_FPG:  addr = {TOP_PAGE, regs.dpl};
            AM_DPT:  addr = {regs.dph, regs.tmp};
            default: addr = {regs.pch, regs.pcl};
        endcase
    end

    always_comb begin
        unique case (rd_sel)
            RS_PCL:  rd_bus = regs.pcl;
            RS_PCH:  rd_bus = regs.pch;
            RS_DPL:  rd_bus = regs.dpl;
            RS_DPH:  rd_bus = regs.dph;
            RS_SP:   rd_bus = regs.sp;
            RS_TMP:  rd_bus = regs.tmp;
            default: rd_bus = '0;
        endcase
    end

endmodule

// File: rtl/addr_reg_unit.sv
module addr_reg_unit
    import addr_unit_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   wbus,
    input  logic [2:0]      wr_sel,
    input  logic [2:0]      inc_sel,
    input  logic [DW-1:0]   dbus,
    input  logic            dph_load,
    input  logic            inhibit_pc,
    input  logic [2:0]      mode,
    input  logic [2:0]      rd_sel,
    input  logic            bus_en_n,
    output logic [DW-1:0]   rd_bus,
    output logic [2*DW-1:0] int_addr,
    output logic [2*DW-1:0] ext_addr
);
    localparam int AW = 2 * DW;

    areg_t          regs;
    inc_sel_e       inc_e;
    logic [AW-1:0]  inc_operand;
    logic [AW-1:0]  sbus;

    assign inc_e = inc_sel_e'(inc_sel);

    always_comb begin
        unique case (inc_e)
            IS_PC:   inc_operand = {regs.pch, regs.pcl};
            IS_DP:   inc_operand = {regs.dph, regs.dpl};
            IS_SP:   inc_operand = {{DW{1'b0}}, regs.sp};
            IS_TMP:  inc_operand = {{DW{1'b0}}, regs.tmp};
            default: inc_operand = '0;
        endcase
    end

    au_incrementer #(.WIDTH(AW), .GROUP(4)) i_inc (
        .operand (inc_operand),
        .result  (sbus)
    );

    au_regfile #(.DW(DW)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .wbus       (wbus),
        .wr_sel     (wr_sel_e'(wr_sel)),
        .inc_sel    (inc_e),
        .sbus       (sbus),
        .dbus       (dbus),
        .dph_load   (dph_load),
        .inhibit_pc (inhibit_pc),
        .regs       (regs)
    );

    au_addr_mux #(.DW(DW)) i_mux (
        .regs   (regs),
        .mode   (addr_mode_e'(mode)),
        .rd_sel (rd_sel_e'(rd_sel)),
        .addr   (int_addr),
        .rd_bus (rd_bus)
    );

    assign ext_addr = bus_en_n ? {AW{1'bz}} : int_addr;

endmodule

// File: tb/test_addr_reg_unit.sv
module test_addr_reg_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  wbus, dbus;
    logic [2:0]  wr_sel, inc_sel, mode, rd_sel;
    logic        dph_load, inhibit_pc, bus_en_n;
    logic [7:0]  rd_bus;
    logic [15:0] int_addr, ext_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] e_pcl, e_pch, e_dpl, e_dph, e_sp, e_tmp;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_reg_unit i_addr_reg_unit (
        .clk(clk), .rst(rst), .wbus(wbus), .wr_sel(wr_sel), .inc_sel(inc_sel),
        .dbus(dbus), .dph_load(dph_load), .inhibit_pc(inhibit_pc), .mode(mode),
        .rd_sel(rd_sel), .bus_en_n(bus_en_n), .rd_bus(rd_bus),
        .int_addr(int_addr), .ext_addr(ext_addr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wbus = 8'h00; dbus = 8'h00; wr_sel = 3'd0; inc_sel = 3'd0;
        dph_load = 1'b0; inhibit_pc = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic load(input logic [2:0] sel, input logic [7:0] val);
        wr_sel = sel; wbus = val;
        step();
    endtask

    task automatic read_all(input string req);
        logic [7:0] exp_v [8];
        exp_v = '{e_pcl, e_pch, e_dpl, e_dph, e_sp, e_tmp, 8'h00, 8'h00};
        for (int s = 0; s < 8; s++) begin
            rd_sel = 3'(s);
            #1;
            chk(req, {8'h00, rd_bus}, {8'h00, exp_v[s]});
        end
    endtask

    initial begin
        idle();
        rst = 1'b1; mode = 3'd0; rd_sel = 3'd0; bus_en_n = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        {e_pcl, e_pch, e_dpl, e_dph, e_sp, e_tmp} = '0;
        read_all("R1");
        chk("R1", int_addr, 16'h0000);

        // R4 write-bus loads, R11 read-bus sweep
        load(3'd1, 8'h34); load(3'd2, 8'h12); load(3'd3, 8'h78);
        load(3'd4, 8'h56); load(3'd5, 8'h9A); load(3'd6, 8'hBC);
        load(3'd0, 8'hEE); load(3'd7, 8'hDD);
        e_pcl = 8'h34; e_pch = 8'h12; e_dpl = 8'h78; e_dph = 8'h56; e_sp = 8'h9A; e_tmp = 8'hBC;
        read_all("R4_R11");

        // R2 address modes, R3 bus enable
        for (int m = 0; m < 8; m++) begin
            logic [15:0] exp_a;
            case (m)
                1: exp_a = {e_dph, e_dpl};
                2: exp_a = {8'h01, e_sp};
                3: exp_a = {8'h00, e_dpl};
                4: exp_a = {8'hFF, e_dpl};
                5: exp_a = {e_dph, e_tmp};
                default: exp_a = {e_pch, e_pcl};
            endcase
            mode = 3'(m); bus_en_n = 1'b0;
            #1;
            chk("R2", int_addr, exp_a);
            chk("R3", ext_addr, exp_a);
            bus_en_n = 1'b1;
            #1;
            checks++;
            if (ext_addr === int_addr) begin
                fails++;
                $display("FAIL R3: actual %h expected released bus", ext_addr);
            end
        end
        bus_en_n = 1'b0;

        // R7 SP sweep across wrap
        load(3'd5, 8'hF0);
        mode = 3'd2;
        for (int i = 1; i <= 300; i++) begin
            inc_sel = 3'd3;
            step();
            chk("R7", int_addr, {8'h01, 8'(8'hF0 + i)});
        end
        // R7 TMP wrap
        load(3'd6, 8'hFE);
        rd_sel = 3'd5;
        for (int i = 1; i <= 4; i++) begin
            inc_sel = 3'd4;
            step();
            chk("R7", {8'h00, rd_bus}, {8'h00, 8'(8'hFE + i)});
        end
        // R7 unused increment codes step nothing
        mode = 3'd0;
        for (int c = 5; c < 8; c++) begin
            inc_sel = 3'(c);
            step();
            chk("R7", int_addr, {e_pch, e_pcl});
        end

        // R6 DP wraps within page
        load(3'd3, 8'hF8); load(3'd4, 8'h56);
        mode = 3'd1;
        for (int i = 1; i <= 20; i++) begin
            inc_sel = 3'd2;
            step();
            chk("R6", int_addr, {8'h56, 8'(8'hF8 + i)});
        end

        // R5 PC sweep across several page boundaries and the top wrap
        load(3'd1, 8'hF0); load(3'd2, 8'h12);
        mode = 3'd0;
        for (int i = 1; i <= 600; i++) begin
            inc_sel = 3'd1;
            step();
            chk("R5", int_addr, 16'(16'h12F0 + i));
        end
        load(3'd1, 8'hFE); load(3'd2, 8'hFF);
        for (int i = 1; i <= 3; i++) begin
            inc_sel = 3'd1;
            step();
            chk("R5", int_addr, 16'(16'hFFFE + i));
        end

        // R9 inhibit blocks loads and increments of PC
        load(3'd1, 8'h11); load(3'd2, 8'h22);
        inhibit_pc = 1'b1; wr_sel = 3'd1; wbus = 8'hAA;
        step();
        chk("R9", int_addr, 16'h2211);
        inhibit_pc = 1'b1; inc_sel = 3'd1;
        step();
        chk("R9", int_addr, 16'h2211);
        inhibit_pc = 1'b1; wr_sel = 3'd2; wbus = 8'h77;
        step();
        chk("R9", int_addr, 16'h2211);

        // R8 direct DPH load wins over write bus
        mode = 3'd1; rd_sel = 3'd3;
        dph_load = 1'b1; dbus = 8'hA5; wr_sel = 3'd4; wbus = 8'h3C;
        step();
        chk("R8", {8'h00, rd_bus}, 16'h00A5);
        load(3'd4, 8'h3C);
        chk("R8", {8'h00, rd_bus}, 16'h003C);
        dph_load = 1'b1; dbus = 8'h5A; inc_sel = 3'd2;
        step();
        chk("R8", {8'h00, rd_bus}, 16'h005A);

        // R10 write bus wins for its byte, other byte still increments
        load(3'd1, 8'hFF); load(3'd2, 8'h12);
        mode = 3'd0;
        wr_sel = 3'd1; wbus = 8'h40; inc_sel = 3'd1;
        step();
        chk("R10", int_addr, 16'h1340);
        wr_sel = 3'd2; wbus = 8'h99; inc_sel = 3'd1;
        step();
        chk("R10", int_addr, 16'h9941);
        load(3'd5, 8'h10);
        wr_sel = 3'd5; wbus = 8'h80; inc_sel = 3'd3;
        step();
        mode = 3'd2;
        #1;
        chk("R10", int_addr, 16'h0180);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule